// File: doc/BRIEF.md
# Multicore Replay Diagnosis Controller

This controller runs after a software-visible symptom has been raised in a small multicore system. It finds the single core whose logic is broken, and it does not depend on any core being known to be healthy. It works through the captured thread traces in short instruction windows. In each window it asks external replay engines to re-execute every thread's trace on a neighbouring core. The engine for each replay slot answers with a done pulse and a flag. The flag says whether that replay disagreed with the thread's original execution.

When any thread disagrees, two suspects remain: the core that first ran that thread and the core that replayed it. The controller then runs two confirmation replays of that one thread, each on a core that is neither suspect. The outcome is a vote over three executions of the thread. If both independent checkers disagree with the original run, the original core is at fault. If both agree with it, the first replaying core is at fault. If the two checkers split, the result is reported as undiagnosed. When the instruction budget runs out without any disagreement, the controller also reports undiagnosed and returns to idle.

Top module: `mrd_ctrl`

## Requirements
- R1: After reset the controller is idle. `busy_o`, `done_o`, `fault_valid_o` and `undiag_o` are 0, no slot requests a replay, and `rep_round_o` is 0.
- R2: A pulse on `symptom_i` while idle arms the controller. A `start_i` pulse while armed makes `busy_o` high on the next cycle. A `start_i` pulse while unarmed is ignored.
- R3: In the first round of each window, all NCORES slots request a replay with `rep_round_o` = 1. Slot k (thread k) is assigned to core (k+1) mod NCORES, so no slot is ever assigned its own core.
- R4: The first window has `rep_base_o` = 0. When a first round finds no divergence and the window is not the last, `rep_base_o` advances by WINDOW_INSNS and a new first round is issued.
- R5: When the window starting at LIMIT_INSNS−WINDOW_INSNS shows no divergence, the controller finishes with `undiag_o` = 1 and `fault_valid_o` = 0. With the defaults this happens after exactly 200 windows.
- R6: When first-round divergence is seen, the lowest-numbered diverging slot t is selected. Round 2 (`rep_round_o` = 2) requests only slot t, on core (t+2) mod NCORES. Round 3 (`rep_round_o` = 3) then requests only slot t, on core (t+3) mod NCORES.
- R7: If both confirmation replays diverge, the faulty core is t. If neither diverges, the faulty core is (t+1) mod NCORES. If exactly one diverges, the result is undiagnosed.
- R8: `done_o` is a one-cycle pulse, accompanied by exactly one of `fault_valid_o` and `undiag_o`. `busy_o` is low on the following cycle, and `fault_core_o` holds the last diagnosed core until a later diagnosis replaces it.
- R9: A symptom pulse that arrives while `busy_o` is high does not arm the controller. A `start_i` pulse after `done_o` therefore does not begin a new diagnosis.
- R10: Each diagnosis uses at most three replay rounds per window. Once divergence is found, exactly two confirmation launches follow.
- R11: A `rep_done_i` or `rep_div_i` pulse on a slot that is not requesting a replay has no effect on the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| symptom_i | input | 1 | Symptom pulse; arms the controller while idle |
| start_i | input | 1 | Start strobe; begins diagnosis when armed |
| rep_req_o | output | NCORES | Per-slot replay request, held until that slot's done |
| rep_core_o | output | NCORES*IDW | Core assigned to each slot, IDW bits per slot |
| rep_round_o | output | 2 | Replay round: 1 rotation, 2 and 3 confirmation |
| rep_base_o | output | BW | First instruction of the current window |
| rep_done_i | input | NCORES | Per-slot replay completion pulse |
| rep_div_i | input | NCORES | Per-slot divergence flag, valid with done |
| busy_o | output | 1 | Diagnosis in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_valid_o | output | 1 | With done: a faulty core was identified |
| fault_core_o | output | IDW | Binary index of the faulty core |
| undiag_o | output | 1 | With done: no core could be identified |

## Verification
A behavioural replay engine in the bench injects a stuck fault on each core in turn. This shows that the rotation and both vote outcomes (both checkers diverge, or neither does) point at the correct core, including when the fault sits on core 0 or on the last core, where the rotation wraps. A fault that only activates in a later window separates window iteration from first-window detection. A fault-free run exercises the instruction budget limit. A fault whose third-round result is inverted checks that a split vote ends as undiagnosed. Spurious completions on idle slots, and symptoms raised during a diagnosis, show that input arriving outside its handshake changes nothing.

// File: rtl/mrd_pkg.sv
// Shared types and helpers for the replay diagnosis controller.
// Assumes nothing beyond plain integer arithmetic.
package mrd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_L1,
        ST_W1,
        ST_E1,
        ST_L2,
        ST_W2,
        ST_L3,
        ST_W3,
        ST_FIN
    } mrd_state_e;

    localparam logic [1:0] RND_NONE   = 2'd0;
    localparam logic [1:0] RND_ROTATE = 2'd1;
    localparam logic [1:0] RND_CHECKA = 2'd2;
    localparam logic [1:0] RND_CHECKB = 2'd3;

    // Core reached by moving idx forward by sh positions on a ring of n cores.
    function automatic int unsigned mrd_rot(input int unsigned idx,
                                            input int unsigned sh,
                                            input int unsigned n);
        return (idx + sh) % n;
    endfunction

endpackage

// File: rtl/mrd_slots.sv
// Replay slot tracker: one slot per thread. On launch, masked slots raise a
// request and clear their divergence flag. A done pulse on a pending slot
// ends the request and captures the divergence flag. Assumes the engine
// answers each request with exactly one done pulse.
module mrd_slots #(
    parameter int NCORES = 4,
    parameter int IDW    = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     launch_i,
    input  logic [NCORES-1:0]        mask_i,
    input  logic [1:0]               shift_i,
    input  logic [NCORES-1:0]        done_i,
    input  logic [NCORES-1:0]        div_i,
    output logic [NCORES-1:0]        req_o,
    output logic [NCORES*IDW-1:0]    core_o,
    output logic [NCORES-1:0]        div_o,
    output logic                     idle_o
);
    import mrd_pkg::*;

    logic [1:0] shift_q;

    // Holds the ring shift of the round that is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)        shift_q <= 2'd0;
        else if (launch_i) shift_q <= shift_i;
    end

    for (genvar k = 0; k < NCORES; k++) begin : g_slot
        logic pend_q;
        logic div_q;

        // Request and divergence capture for one slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q <= 1'b0;
                div_q  <= 1'b0;
            end else if (launch_i && mask_i[k]) begin
                pend_q <= 1'b1;
                div_q  <= 1'b0;
            end else if (pend_q && done_i[k]) begin
                pend_q <= 1'b0;
                div_q  <= div_i[k];
            end
        end

        assign req_o[k] = pend_q;
        assign div_o[k] = div_q;
        assign core_o[k*IDW +: IDW] = IDW'(mrd_rot(k, 32'(shift_q), NCORES));

        assert_not_own_core_R3: assert property (@(posedge clk) disable iff (!rst_n)
            pend_q |-> (core_o[k*IDW +: IDW] != IDW'(k)));
    end

    assign idle_o = ~|req_o;

    assert_no_relaunch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |-> idle_o);

endmodule

// File: rtl/mrd_window.sv
// Instruction window tracker: holds the first instruction of the current
// window and flags the last window that fits inside the budget. Assumes
// WINDOW is non-zero and not larger than LIMIT.
module mrd_window #(
    parameter int WINDOW = 100000,
    parameter int LIMIT  = 20000000,
    parameter int BW     = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          step_i,
    output logic [BW-1:0] base_o,
    output logic          last_o
);
    localparam logic [BW:0] WIN_W = (BW+1)'(WINDOW);
    localparam logic [BW:0] LIM_W = (BW+1)'(LIMIT);

    logic [BW-1:0] base_q;

    // Window start: cleared per diagnosis, advanced per clean window.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (clear_i) base_q <= '0;
        else if (step_i)  base_q <= base_q + WIN_W[BW-1:0];
    end

    assign base_o = base_q;
    assign last_o = ({1'b0, base_q} + WIN_W) >= LIM_W;

    assert_base_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, base_q} < LIM_W);

    assert_no_step_past_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> !last_o);

endmodule

// File: rtl/mrd_vote.sv
// Vote logic: picks the lowest diverging thread from the rotation round and
// turns the two confirmation results into a verdict. Assumes one faulty core.
module mrd_vote #(
    parameter int NCORES = 4,
    parameter int IDW    = 2
) (
    input  logic [NCORES-1:0] div_i,
    input  logic [IDW-1:0]    sel_i,
    input  logic              chk2_i,
    input  logic              chk3_i,
    output logic              any_o,
    output logic [IDW-1:0]    pick_o,
    output logic              ok_o,
    output logic [IDW-1:0]    core_o
);
    import mrd_pkg::*;

    // Priority pick: the lowest diverging slot wins.
    always_comb begin
        pick_o = '0;
        for (int k = NCORES - 1; k >= 0; k--) begin
            if (div_i[k]) pick_o = IDW'(k);
        end
    end

    // Verdict: both checkers against the original blame the original core.
    always_comb begin
        any_o  = |div_i;
        ok_o   = (chk2_i == chk3_i);
        core_o = chk2_i ? sel_i : IDW'(mrd_rot(32'(sel_i), 1, NCORES));
    end

endmodule

// File: rtl/mrd_ctrl.sv
// Replay diagnosis controller top. Sequences rotation rounds window by
// window, then two confirmation rounds on non-suspect cores, and reports a
// faulty core or an undiagnosed result. Assumes NCORES >= 4, so that the two
// checkers differ from both suspects, and at most one faulty core.
module mrd_ctrl #(
    parameter int NCORES       = 4,
    parameter int WINDOW_INSNS = 100000,
    parameter int LIMIT_INSNS  = 20000000,
    localparam int IDW = (NCORES > 1) ? $clog2(NCORES) : 1,
    localparam int BW  = $clog2(LIMIT_INSNS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  symptom_i,
    input  logic                  start_i,
    output logic [NCORES-1:0]     rep_req_o,
    output logic [NCORES*IDW-1:0] rep_core_o,
    output logic [1:0]            rep_round_o,
    output logic [BW-1:0]         rep_base_o,
    input  logic [NCORES-1:0]     rep_done_i,
    input  logic [NCORES-1:0]     rep_div_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  fault_valid_o,
    output logic [IDW-1:0]        fault_core_o,
    output logic                  undiag_o
);
    import mrd_pkg::*;

    mrd_state_e        state_q, state_d;
    logic              armed_q;
    logic [IDW-1:0]    sel_q;
    logic              chk2_q;
    logic [1:0]        round_q;
    logic              ok_q;
    logic [IDW-1:0]    core_q;

    logic              go;
    logic              launch;
    logic [NCORES-1:0] mask;
    logic [1:0]        shift;
    logic              win_clear, win_step, win_last;
    logic [NCORES-1:0] slot_div;
    logic              slots_idle;
    logic              v_any, v_ok;
    logic [IDW-1:0]    v_pick, v_core;

    assign go = (state_q == ST_IDLE) && start_i && armed_q;

    mrd_slots #(.NCORES(NCORES), .IDW(IDW)) u_slots (
        .clk(clk), .rst_n(rst_n),
        .launch_i(launch), .mask_i(mask), .shift_i(shift),
        .done_i(rep_done_i), .div_i(rep_div_i),
        .req_o(rep_req_o), .core_o(rep_core_o),
        .div_o(slot_div), .idle_o(slots_idle)
    );

    mrd_window #(.WINDOW(WINDOW_INSNS), .LIMIT(LIMIT_INSNS), .BW(BW)) u_win (
        .clk(clk), .rst_n(rst_n),
        .clear_i(win_clear), .step_i(win_step),
        .base_o(rep_base_o), .last_o(win_last)
    );

    mrd_vote #(.NCORES(NCORES), .IDW(IDW)) u_vote (
        .div_i(slot_div), .sel_i(sel_q),
        .chk2_i(chk2_q), .chk3_i(slot_div[sel_q]),
        .any_o(v_any), .pick_o(v_pick), .ok_o(v_ok), .core_o(v_core)
    );

    // Launch controls for the round that starts in this state.
    always_comb begin
        launch = 1'b0;
        mask   = '0;
        shift  = 2'd1;
        unique case (state_q)
            ST_L1: begin launch = 1'b1; mask = '1; shift = 2'd1; end
            ST_L2: begin launch = 1'b1; mask = NCORES'(1) << sel_q; shift = 2'd2; end
            ST_L3: begin launch = 1'b1; mask = NCORES'(1) << sel_q; shift = 2'd3; end
            default: ;
        endcase
        win_clear = go;
        win_step  = (state_q == ST_E1) && !v_any && !win_last;
    end

    // Next-state sequencing through rotation and confirmation rounds.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go) state_d = ST_L1;
            ST_L1:   state_d = ST_W1;
            ST_W1:   if (slots_idle) state_d = ST_E1;
            ST_E1:   if (v_any) state_d = ST_L2;
                     else if (win_last) state_d = ST_FIN;
                     else state_d = ST_L1;
            ST_L2:   state_d = ST_W2;
            ST_W2:   if (slots_idle) state_d = ST_L3;
            ST_L3:   state_d = ST_W3;
            ST_W3:   if (slots_idle) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and symptom arming; symptoms count only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            armed_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (go)                                     armed_q <= 1'b0;
            else if (state_q == ST_IDLE && symptom_i)   armed_q <= 1'b1;
        end
    end

    // Round code, chosen thread, first checker result and final verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            round_q <= RND_NONE;
            sel_q   <= '0;
            chk2_q  <= 1'b0;
            ok_q    <= 1'b0;
            core_q  <= '0;
        end else begin
            unique case (state_q)
                ST_L1:  round_q <= RND_ROTATE;
                ST_L2:  round_q <= RND_CHECKA;
                ST_L3:  round_q <= RND_CHECKB;
                ST_E1: begin
                    if (v_any)         sel_q <= v_pick;
                    else if (win_last) ok_q  <= 1'b0;
                end
                ST_W2:  if (slots_idle) chk2_q <= slot_div[sel_q];
                ST_W3: begin
                    if (slots_idle) begin
                        ok_q <= v_ok;
                        if (v_ok) core_q <= v_core;
                    end
                end
                ST_FIN: round_q <= RND_NONE;
                default: ;
            endcase
        end
    end

    assign rep_round_o   = round_q;
    assign busy_o        = (state_q != ST_IDLE);
    assign done_o        = (state_q == ST_FIN);
    assign fault_valid_o = done_o && ok_q;
    assign undiag_o      = done_o && !ok_q;
    assign fault_core_o  = core_q;

    assert_start_needs_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    assert_confirm_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_round_o >= RND_CHECKA) |-> $onehot0(rep_req_o));

    assert_round_coded_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|rep_req_o) |-> (rep_round_o != RND_NONE));

    assert_done_then_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    assert_no_arm_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && symptom_i) |=> !armed_q);

endmodule

// File: tb/sim_mrd_ctrl.sv
module sim_mrd_ctrl;
    localparam int N   = 4;
    localparam int IDW = 2;
    localparam int BW  = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic symptom_i = 1'b0;
    logic start_i = 1'b0;
    logic [N-1:0] rep_req_o;
    logic [N*IDW-1:0] rep_core_o;
    logic [1:0] rep_round_o;
    logic [BW-1:0] rep_base_o;
    logic [N-1:0] rep_done_i;
    logic [N-1:0] rep_div_i;
    logic busy_o, done_o, fault_valid_o, undiag_o;
    logic [IDW-1:0] fault_core_o;

    int tests = 0;
    int fails = 0;

    // engine model state
    int  fault_core = -1;
    int  act_base = 0;
    bit  flip3 = 1'b0;
    bit  spur_en = 1'b0;
    int  rot_err = 0;
    int  win_cnt = 0;
    int  last_base = 0;
    int  conf_cnt = 0;
    int  conf_slot = -1;
    int  conf_core2 = -1;
    int  conf_core3 = -1;
    int  max_round = 0;

    // diagnosis results
    bit  r_busy1, r_fv, r_ud, r_busy_after, r_done_after;
    int  r_core;

    always #10 clk = ~clk;

    mrd_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .symptom_i(symptom_i), .start_i(start_i),
        .rep_req_o(rep_req_o), .rep_core_o(rep_core_o), .rep_round_o(rep_round_o),
        .rep_base_o(rep_base_o), .rep_done_i(rep_done_i), .rep_div_i(rep_div_i),
        .busy_o(busy_o), .done_o(done_o), .fault_valid_o(fault_valid_o),
        .fault_core_o(fault_core_o), .undiag_o(undiag_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural replay engine: answers each request on the next falling edge.
    initial begin
        logic [N-1:0] d, v, prev;
        prev = '0;
        rep_done_i = '0;
        rep_div_i = '0;
        forever begin
            @(negedge clk);
            d = rep_req_o;
            v = '0;
            for (int k = 0; k < N; k++) begin
                if (rep_req_o[k]) begin
                    int core;
                    bit act, ob, rb;
                    core = int'(rep_core_o[k*IDW +: IDW]);
                    if (core != (k + int'(rep_round_o)) % N) rot_err++;
                    act = (fault_core >= 0) && (int'(rep_base_o) >= act_base);
                    ob = act && (k == fault_core);
                    rb = act && (core == fault_core);
                    v[k] = ob ^ rb;
                    if (flip3 && rep_round_o == 2'd3) v[k] = ~v[k];
                    if (prev == '0) begin
                        if (rep_round_o == 2'd2) begin conf_slot = k; conf_core2 = core; end
                        if (rep_round_o == 2'd3) conf_core3 = core;
                    end
                end else if (spur_en && rep_round_o >= 2'd2) begin
                    d[k] = 1'b1;
                    v[k] = 1'b1;
                end
            end
            if (rep_req_o != '0 && prev == '0) begin
                if (rep_round_o == 2'd1) begin
                    win_cnt++;
                    last_base = int'(rep_base_o);
                end else conf_cnt++;
                if (int'(rep_round_o) > max_round) max_round = int'(rep_round_o);
            end
            prev = rep_req_o;
            rep_done_i = d;
            rep_div_i = v;
        end
    end

    task automatic diagnose(input int f, input int act, input bit flip, input bit spur,
                            input bit sym_mid);
        int cyc;
        fault_core = f; act_base = act; flip3 = flip; spur_en = spur;
        rot_err = 0; win_cnt = 0; conf_cnt = 0; conf_slot = -1;
        conf_core2 = -1; conf_core3 = -1; max_round = 0;
        @(negedge clk) symptom_i = 1'b1;
        @(negedge clk) begin symptom_i = 1'b0; start_i = 1'b1; end
        @(negedge clk) begin start_i = 1'b0; r_busy1 = busy_o; end
        cyc = 0;
        while (!done_o && cyc < 5000) begin
            if (sym_mid && cyc == 3) symptom_i = 1'b1;
            else symptom_i = 1'b0;
            @(negedge clk);
            cyc++;
        end
        symptom_i = 1'b0;
        r_fv = fault_valid_o; r_ud = undiag_o; r_core = int'(fault_core_o);
        @(negedge clk);
        r_busy_after = busy_o; r_done_after = done_o;
    endtask

    task automatic t_reset();
        chk(busy_o == 0, "R1 busy", busy_o, 0);
        chk(rep_req_o == 0, "R1 req", int'(rep_req_o), 0);
        chk({done_o, fault_valid_o, undiag_o} == 0, "R1 done/valid/undiag",
            int'({done_o, fault_valid_o, undiag_o}), 0);
        chk(rep_round_o == 0, "R1 round", rep_round_o, 0);
    endtask

    task automatic t_start_gate();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        chk(busy_o == 0, "R2 unarmed start ignored", busy_o, 0);
        @(negedge clk);
        chk(busy_o == 0, "R2 unarmed start still idle", busy_o, 0);
    endtask

    task automatic t_locate(input int f);
        int t;
        t = (f == 0) ? 0 : f - 1;
        diagnose(f, 0, 1'b0, 1'b0, 1'b0);
        chk(r_busy1 == 1, "R2 busy after armed start", r_busy1, 1);
        chk(r_fv == 1 && r_ud == 0, "R7 verdict valid", int'({r_fv, r_ud}), 2);
        chk(r_core == f, "R7 faulty core", r_core, f);
        chk(rot_err == 0, "R3 rotation map", rot_err, 0);
        chk(win_cnt == 1, "R4 single window", win_cnt, 1);
        chk(conf_slot == t, "R6 selected thread", conf_slot, t);
        chk(conf_core2 == (t + 2) % N, "R6 round2 core", conf_core2, (t + 2) % N);
        chk(conf_core3 == (t + 3) % N, "R6 round3 core", conf_core3, (t + 3) % N);
        chk(conf_cnt == 2 && max_round == 3, "R10 confirm rounds", conf_cnt * 10 + max_round, 23);
        chk(r_busy_after == 0 && r_done_after == 0, "R8 done pulse then idle",
            int'({r_busy_after, r_done_after}), 0);
    endtask

    task automatic t_late();
        diagnose(2, 300000, 1'b0, 1'b0, 1'b0);
        chk(win_cnt == 4, "R4 windows until late fault", win_cnt, 4);
        chk(last_base == 300000, "R4 window base", last_base, 300000);
        chk(r_fv == 1 && r_core == 2, "R4 late fault core", r_core, 2);
    endtask

    task automatic t_limit();
        diagnose(-1, 0, 1'b0, 1'b0, 1'b0);
        chk(r_ud == 1 && r_fv == 0, "R5 undiagnosed at limit", int'({r_fv, r_ud}), 1);
        chk(win_cnt == 200, "R5 window count", win_cnt, 200);
        chk(last_base == 19900000, "R5 last base", last_base, 19900000);
        chk(conf_cnt == 0, "R10 no confirm without divergence", conf_cnt, 0);
        chk(rot_err == 0, "R3 rotation over many windows", rot_err, 0);
    endtask

    task automatic t_disagree();
        diagnose(1, 0, 1'b1, 1'b0, 1'b0);
        chk(r_ud == 1 && r_fv == 0, "R7 split vote undiagnosed", int'({r_fv, r_ud}), 1);
        chk(r_core == 3, "R8 core held from previous verdict", r_core, 3);
    endtask

    task automatic t_ignore();
        diagnose(3, 0, 1'b0, 1'b0, 1'b1);
        chk(r_fv == 1 && r_core == 3, "R9 result despite mid symptom", r_core, 3);
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        chk(busy_o == 0, "R9 mid symptom did not arm", busy_o, 0);
        chk(fault_core_o == 3, "R8 core held while idle", int'(fault_core_o), 3);
    endtask

    task automatic t_spur();
        diagnose(3, 0, 1'b0, 1'b1, 1'b0);
        chk(r_fv == 1 && r_core == 3, "R11 spurious done ignored", r_core, 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_start_gate();
        for (int f = 0; f < N; f++) t_locate(f);
        t_late();
        t_limit();
        t_ignore();
        t_disagree();
        t_spur();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule